// File: doc/BRIEF.md
# Dot Clock PLL Setting Search

This block takes a requested pixel clock in kHz and finds the PLL multiplier N and post-divider M whose output comes closest to the request without going above it. It walks the divider range for the selected output channel from the smallest M upward. For each M it computes a candidate N and the resulting frequency with a shared iterative restoring divider. It keeps the best candidate in local registers.

Two clocking schemes are supported. In the narrow scheme the PLL step is 3000 kHz. Each divider value is tried on the plain path, and odd divider values are also tried on the doubled path, where the step counts twice. In the wide scheme the step is 6000 kHz, the plain path is never tried, and every divider value is tried on the doubled path. The result is reported on a one-cycle done pulse and stays on the outputs until the next search completes. A result of N = 0 means no setting is usable, and that case is flagged separately.

Top module: `dclk_pll_search`

## Requirements
- R1: A candidate multiplier is N = floor(M × target / S), where S is the step of the path being tried. It is accepted only when 9 ≤ N ≤ 127, so every reported non-zero N lies in that range.
- R2: A candidate's frequency is floor(S × N / M) and its error is the target minus that frequency. A candidate replaces the held best only when its error is strictly smaller, starting from an initial error of 0x0FFFFFFF. Divider values are scanned in increasing order, and within one M the plain path is tried before the doubled path.
- R3: In the narrow scheme (wide_i = 0) the step is 3000 kHz. The doubled path uses S = 6000 kHz and is tried only for odd M, so a reported doubled result always has an odd M.
- R4: In the wide scheme (wide_i = 1) the plain path is skipped, and the doubled path uses S = 12000 kHz for every M. Any solution found there reports dbl_o = 1.
- R5: The divider range is 1..15 when chan1_i = 1, exactly 7 when chan1_i = 0 and lvds_i = 1, and 6..127 when chan1_i = 0 and lvds_i = 0.
- R6: none_o = 1 exactly when the finished search kept no candidate. In that case best_n_o, best_m_o and dbl_o are all 0.
- R7: A start in the idle state raises busy_o on the next cycle. done_o is high for exactly one cycle, in the cycle busy_o falls.
- R8: start_i is ignored while busy_o = 1. The running search continues, and its result is the one for the request accepted first.
- R9: After reset all outputs are 0. The result outputs change only in the cycle done_o is high and otherwise hold, including during a later search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a search (taken only when idle) |
| dot_khz_i | input | 18 | Requested dot clock in kHz |
| chan1_i | input | 1 | 1 selects the second output channel divider range |
| lvds_i | input | 1 | Serial-link mode for channel 0 (fixed divider) |
| wide_i | input | 1 | Wide scheme: 6000 kHz step, doubled path only |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| best_n_o | output | 7 | Chosen PLL multiplier (0 if none) |
| best_m_o | output | 7 | Chosen divider (0 if none) |
| dbl_o | output | 1 | Chosen setting uses the doubled path |
| none_o | output | 1 | No valid setting found |

## Verification
A corrupted divider quotient or remainder gives a wrong N or M at the next done pulse, because every candidate passes through the same divider. A bad comparison shows up the same way, through a different tie-break or a result above the target. A wrong scan counter or path flag shows up as an M outside the channel's range, as an even M with the doubled flag in the narrow scheme, or as a search that ends too early or never ends. A broken hold or handshake shows within a cycle as outputs moving without done_o, or as done_o lasting more than one cycle. Comparing each completed result against an independent model therefore exposes internal faults no later than the end of the affected search.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISS_N,
    ST_WAIT_N,
    ST_ISS_F,
    ST_WAIT_F,
    ST_ADV
  } srch_st_e;

  localparam int ERR_W = 28;
  localparam logic [ERR_W-1:0] ERR_INIT = 28'h0FFFFFFF;
endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
  parameter int NUM_W = 25,
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             fin_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q, acc_d;
  logic [DEN_W-1:0] rem_q, rem_d, den_q, den_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin_q, fin_d;
  logic [DEN_W:0]   trial, diff;
  logic             active, fits, upd_en;

  assign active = (cnt_q != '0);
  assign trial  = {rem_q, acc_q[NUM_W-1]};
  assign diff   = trial - {1'b0, den_q};
  assign fits   = ~diff[DEN_W];
  assign upd_en = go_i | active;

  always_comb begin
    acc_d = acc_q;
    rem_d = rem_q;
    den_d = den_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (go_i) begin
      acc_d = num_i;
      rem_d = '0;
      den_d = den_i;
      cnt_d = CNT_W'(NUM_W);
    end else if (active) begin
      acc_d = {acc_q[NUM_W-2:0], fits};
      rem_d = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_d = cnt_q - 1'b1;
      fin_d = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin_d;
      if (upd_en) begin
        acc_q <= acc_d;
        rem_q <= rem_d;
        den_q <= den_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign quo_o = acc_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/pll_m_range.sv
module pll_m_range #(
  parameter int M_W        = 7,
  parameter int CH0_LO     = 6,
  parameter int CH0_HI     = 127,
  parameter int SERIAL_M   = 7,
  parameter int CH1_LO     = 1,
  parameter int CH1_HI     = 15
) (
  input  logic           chan1_i,
  input  logic           lvds_i,
  output logic [M_W-1:0] m_lo_o,
  output logic [M_W-1:0] m_hi_o
);
  always_comb begin
    if (chan1_i) begin
      m_lo_o = M_W'(CH1_LO);
      m_hi_o = M_W'(CH1_HI);
    end else if (lvds_i) begin
      m_lo_o = M_W'(SERIAL_M);
      m_hi_o = M_W'(SERIAL_M);
    end else begin
      m_lo_o = M_W'(CH0_LO);
      m_hi_o = M_W'(CH0_HI);
    end
  end
endmodule

// File: rtl/dclk_pll_search.sv
module dclk_pll_search
  import pll_search_pkg::*;
#(
  parameter int TGT_W       = 18,
  parameter int M_W         = 7,
  parameter int N_MIN       = 9,
  parameter int N_MAX       = 127,
  parameter int STEP_NARROW = 3000,
  parameter int STEP_WIDE   = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [TGT_W-1:0] dot_khz_i,
  input  logic             chan1_i,
  input  logic             lvds_i,
  input  logic             wide_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [M_W-1:0]   best_n_o,
  output logic [M_W-1:0]   best_m_o,
  output logic             dbl_o,
  output logic             none_o
);
  localparam int NUM_W  = TGT_W + M_W;
  localparam int STEP_B = $clog2(2 * STEP_WIDE + 1);
  localparam int DEN_W  = (STEP_B > M_W) ? STEP_B : M_W;

  srch_st_e st_q, st_d;
  logic [TGT_W-1:0] dot_q;
  logic             ch1_q, lvds_q, wide_q, path_q, path_d;
  logic [M_W-1:0]   m_q, m_d, cand_n_q, bn_q, bm_q;
  logic             bd_q;
  logic [ERR_W-1:0] berr_q;
  logic [M_W-1:0]   m_lo, m_hi;
  logic [DEN_W-1:0] base_step, cur_step, div_den;
  logic [NUM_W-1:0] div_num, quo, err_full;
  logic             div_go, div_fin, n_ok, better, accept, finish, cand_en;
  logic             done_q;
  logic [M_W-1:0]   on_q, om_q;
  logic             od_q, onone_q;

  pll_m_range #(.M_W(M_W)) u_range (
    .chan1_i(ch1_q), .lvds_i(lvds_q), .m_lo_o(m_lo), .m_hi_o(m_hi)
  );

  assign base_step = wide_q ? DEN_W'(STEP_WIDE) : DEN_W'(STEP_NARROW);
  assign cur_step  = path_q ? (base_step << 1) : base_step;
  assign div_go    = (st_q == ST_ISS_N) || (st_q == ST_ISS_F);
  assign div_num   = (st_q == ST_ISS_N) ? NUM_W'(dot_q) * NUM_W'(m_q)
                                        : NUM_W'(cur_step) * NUM_W'(cand_n_q);
  assign div_den   = (st_q == ST_ISS_N) ? cur_step : DEN_W'(m_q);

  pll_srch_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(div_num),
    .den_i(div_den), .quo_o(quo), .fin_o(div_fin)
  );

  assign n_ok     = (quo >= NUM_W'(N_MIN)) && (quo <= NUM_W'(N_MAX));
  assign err_full = NUM_W'(dot_q) - quo;
  assign better   = (ERR_W'(err_full) < berr_q);
  assign accept   = (st_q == ST_IDLE) && start_i;
  assign cand_en  = (st_q == ST_WAIT_N) && div_fin && n_ok;

  always_comb begin
    st_d   = st_q;
    m_d    = m_q;
    path_d = path_q;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_ISS_N;
      ST_ISS_N:  st_d = ST_WAIT_N;
      ST_WAIT_N: if (div_fin) st_d = n_ok ? ST_ISS_F : ST_ADV;
      ST_ISS_F:  st_d = ST_WAIT_F;
      ST_WAIT_F: if (div_fin) st_d = ST_ADV;
      ST_ADV: begin
        if (!path_q && m_q[0]) begin
          path_d = 1'b1;
          st_d   = ST_ISS_N;
        end else if (m_q == m_hi) begin
          finish = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          m_d    = m_q + 1'b1;
          path_d = wide_q;
          st_d   = ST_ISS_N;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dot_q    <= '0;
      ch1_q    <= 1'b0;
      lvds_q   <= 1'b0;
      wide_q   <= 1'b0;
      path_q   <= 1'b0;
      m_q      <= '0;
      cand_n_q <= '0;
      bn_q     <= '0;
      bm_q     <= '0;
      bd_q     <= 1'b0;
      berr_q   <= ERR_INIT;
      done_q   <= 1'b0;
      on_q     <= '0;
      om_q     <= '0;
      od_q     <= 1'b0;
      onone_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
      if (accept) begin
        dot_q  <= dot_khz_i;
        ch1_q  <= chan1_i;
        lvds_q <= lvds_i;
        wide_q <= wide_i;
        path_q <= wide_i;
        m_q    <= chan1_i ? M_W'(1) : (lvds_i ? M_W'(7) : M_W'(6));
        bn_q   <= '0;
        bm_q   <= '0;
        bd_q   <= 1'b0;
        berr_q <= ERR_INIT;
      end else begin
        m_q    <= m_d;
        path_q <= path_d;
      end
      if (cand_en) cand_n_q <= quo[M_W-1:0];
      if ((st_q == ST_WAIT_F) && div_fin && better) begin
        berr_q <= ERR_W'(err_full);
        bn_q   <= cand_n_q;
        bm_q   <= m_q;
        bd_q   <= path_q;
      end
      if (finish) begin
        on_q    <= bn_q;
        om_q    <= bm_q;
        od_q    <= bd_q;
        onone_q <= (bn_q == '0);
      end
    end
  end

  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = done_q;
  assign best_n_o = on_q;
  assign best_m_o = om_q;
  assign dbl_o    = od_q;
  assign none_o   = onone_q;
endmodule

module dclk_pll_search_chk #(
  parameter int TGT_W = 18,
  parameter int M_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [TGT_W-1:0] dot_khz_i,
  input logic             chan1_i,
  input logic             lvds_i,
  input logic             wide_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [M_W-1:0]   best_n_o,
  input logic [M_W-1:0]   best_m_o,
  input logic             dbl_o,
  input logic             none_o
);
  logic c_ch1, c_lvds, c_wide;
  logic unused_dot;
  assign unused_dot = ^dot_khz_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_ch1  <= 1'b0;
      c_lvds <= 1'b0;
      c_wide <= 1'b0;
    end else if (start_i && !busy_o) begin
      c_ch1  <= chan1_i;
      c_lvds <= lvds_i;
      c_wide <= wide_i;
    end
  end

  // R1
  n_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !none_o) |-> (best_n_o >= 7'd9 && best_n_o <= 7'd127));
  // R3
  odd_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && dbl_o && !c_wide) |-> best_m_o[0]);
  // R4
  wide_dbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !none_o && c_wide) |-> dbl_o);
  // R5
  m_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !none_o) |->
      (c_ch1 ? (best_m_o >= 7'd1 && best_m_o <= 7'd15)
             : (c_lvds ? (best_m_o == 7'd7) : (best_m_o >= 7'd6))));
  // R6
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    none_o |-> (best_m_o == '0 && !dbl_o && best_n_o == '0));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(best_n_o) && $stable(best_m_o) && $stable(dbl_o) && $stable(none_o)));
endmodule

bind dclk_pll_search dclk_pll_search_chk #(.TGT_W(TGT_W), .M_W(M_W)) u_chk (.*);

// File: tb/dclk_pll_search_tb.sv
module dclk_pll_search_tb_top;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [17:0] dot_khz_i;
  logic        chan1_i, lvds_i, wide_i;
  logic        busy_o, done_o, dbl_o, none_o;
  logic [6:0]  best_n_o, best_m_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  dclk_pll_search dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dot_khz_i(dot_khz_i),
    .chan1_i(chan1_i), .lvds_i(lvds_i), .wide_i(wide_i), .busy_o(busy_o),
    .done_o(done_o), .best_n_o(best_n_o), .best_m_o(best_m_o),
    .dbl_o(dbl_o), .none_o(none_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_search(input longint dot, input bit c1, input bit lv,
                                     input bit wd, output int rn, output int rm, output int rd);
    longint base = wd ? 6000 : 3000;
    longint bd = 64'h0FFFFFFF;
    int lo = c1 ? 1 : (lv ? 7 : 6);
    int hi = c1 ? 15 : (lv ? 7 : 127);
    rn = 0; rm = 0; rd = 0;
    for (int m = lo; m <= hi; m++) begin
      longint n, v, d;
      if (!wd) begin
        n = (m * dot) / base;
        if (n >= 9 && n <= 127) begin
          v = (base * n) / m; d = dot - v;
          if (d < bd) begin bd = d; rn = int'(n); rm = m; rd = 0; end
        end
        if ((m % 2) == 0) continue;
      end
      n = (m * dot) / (2 * base);
      if (n >= 9 && n <= 127) begin
        v = (2 * base * n) / m; d = dot - v;
        if (d < bd) begin bd = d; rn = int'(n); rm = m; rd = 1; end
      end
    end
  endfunction

  task automatic launch(input int dot, input bit c1, input bit lv, input bit wd);
    @(negedge clk);
    dot_khz_i = 18'(dot); chan1_i = c1; lvds_i = lv; wide_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
  endtask

  task automatic finish_and_check(input int dot, input bit c1, input bit lv, input bit wd,
                                  input bit disturb);
    int en, em, ed;
    ref_search(dot, c1, lv, wd, en, em, ed);
    if (disturb) begin
      repeat (5) @(negedge clk);
      // R8: foreign request while busy must be dropped
      dot_khz_i = 18'd1000; chan1_i = ~c1; lvds_i = ~lv; wide_i = ~wd; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk(best_n_o == 7'(en), disturb ? "R8 n" : "R1/R2 n", best_n_o, en);
    chk(best_m_o == 7'(em), disturb ? "R8 m" : "R5/R2 m", best_m_o, em);
    chk(dbl_o == ed[0], wd ? "R4 dbl" : "R3 dbl", dbl_o, ed);
    chk(none_o == (en == 0), "R6 none", none_o, en == 0);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7 done one cycle", done_o, 0);
  endtask

  task automatic search(input int dot, input bit c1, input bit lv, input bit wd);
    launch(dot, c1, lv, wd);
    finish_and_check(dot, c1, lv, wd, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pn, pm;
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; dot_khz_i = '0;
    chan1_i = 1'b0; lvds_i = 1'b0; wide_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(best_n_o == 0 && best_m_o == 0 && !dbl_o && !none_o && !done_o && !busy_o,
        "R9 reset", {best_n_o, best_m_o}, 0);

    search(33000, 1'b1, 1'b0, 1'b0);   // R3 channel 1 narrow
    search(65000, 1'b0, 1'b1, 1'b0);   // R5 fixed divider
    search(60000, 1'b0, 1'b1, 1'b0);   // R3 plain path overflows N
    search(1000,  1'b1, 1'b0, 1'b0);   // R6 too slow
    search(200000, 1'b0, 1'b1, 1'b0);  // R6 too fast
    search(148500, 1'b0, 1'b0, 1'b1);  // R4 wide scheme
    search(27000, 1'b0, 1'b0, 1'b0);   // R2 channel 0 parallel, exact hit

    // R8 start while busy
    launch(74250, 1'b1, 1'b0, 1'b0);
    finish_and_check(74250, 1'b1, 1'b0, 1'b0, 1'b1);

    // R9 outputs hold during a following search
    pn = best_n_o; pm = best_m_o;
    launch(40000, 1'b1, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk(best_n_o == 7'(pn) && best_m_o == 7'(pm), "R9 hold", best_n_o, pn);
    finish_and_check(40000, 1'b1, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < 22; i++) begin
      int sel = $urandom_range(0, 3);
      int dot = 5000 + $urandom_range(0, 200000);
      bit wd = 1'($urandom_range(0, 1));
      search(dot, sel >= 2, sel == 1, wd);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule